// File: doc/BRIEF.md
# Rijndael-256 Round Engine

This block encrypts one 256-bit Rijndael block, a state of eight columns by four rows of bytes, by running it as two 128-bit lanes through ordinary 128-bit AES round logic. Before each round, a fixed byte exchange between the lanes and a fixed byte permutation inside each lane place the bytes so that the 4-column row rotation of the AES round produces the 8-column row rotation of the wide cipher. Each round therefore costs two standard AES round datapaths side by side.

A start pulse in the idle state loads the block XORed with the whitening key pair. The engine then runs one round per clock, up to the round count `NR` (default 14), and pulses `done`. Round keys are not generated here. The engine drives `key_round` with the index of the key pair it consumes, and the surrounding logic returns the two 128-bit key words for that index on the same cycle.

Top module: `rd256_round_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`=0, `done`=0, `key_round`=0 and `block_out`=0.
- R2: While idle, `key_round` is 0. A `start` sampled high while idle loads `block_in ^ {key_odd, key_even}` into the state and raises `busy` on the next cycle.
- R3: Byte k of a 256-bit block or key pair sits at bits 8k+7:8k and holds row k%4, column k/4. The low lane (bits 127:0, `key_even`) covers columns 0 to 3 and the high lane (`key_odd`) covers columns 4 to 7.
- R4: A round with `key_round` below `NR` rotates row r left by 0, 1, 3, 4 places for r = 0..3 across all eight columns. It then applies the AES S-box to every byte and the AES column mix (polynomial 0x11b) to every column, and XORs the key pair presented for that index.
- R5: The round with `key_round` equal to `NR` is the same as R4 without the column mix.
- R6: While busy, `key_round` steps through 1..NR, one value per cycle. The cycle after round NR shows `done`=1 for exactly one cycle, together with `busy`=0.
- R7: A `start` sampled while busy has no effect on the state, the round sequence or the result.
- R8: While idle with `start` low, `block_out` holds its value, so a finished result stays readable until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a block; accepted only while idle |
| block_in | input | 256 | Plaintext block, sampled with an accepted start |
| key_round | output | $clog2(NR+1) | Index of the key pair consumed this cycle |
| key_even | input | 128 | Key word for columns 0-3 at index `key_round` |
| key_odd | input | 128 | Key word for columns 4-7 at index `key_round` |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse after the final round |
| block_out | output | 256 | Current state; the ciphertext once `done` has pulsed |

## Verification
The assertions assume that the key source answers combinationally for the index shown on `key_round`, and that `start` may be high in any cycle, including while busy and in the cycle `done` is high. The stimulus drives keys from a function of `key_round` and holds the key seed still during a block. It also raises `start` during rounds, holds it high across back-to-back blocks, and resets once in the middle of a block, so the start-handling and sequencing properties get exercised under these conditions.

// File: rtl/rd256_pkg.sv
// Shared constants, types and byte-level functions for the Rijndael-256
// round engine. Assumes the AES field polynomial 0x11b throughout.
package rd256_pkg;

    localparam int LANE_W     = 128;
    localparam int LANE_BYTES = LANE_W / 8;
    localparam int COLS_LANE  = LANE_BYTES / 4;

    // Lane-exchange mask: a byte whose top bit is set is swapped between lanes.
    localparam logic [LANE_W-1:0] XFER_MASK =
        128'h80000000_80800000_80800000_80808000;
    // Per-lane permutation: output byte i takes input byte PERM_MASK byte i.
    localparam logic [LANE_W-1:0] PERM_MASK =
        128'h03020d0c_0f0e0908_0b0a0504_07060100;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    // Multiply by x in GF(2^8).
    function automatic logic [7:0] xtime(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // Rotate a byte left by n places.
    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    // S-box: inverse as v^254, then the affine map.
    function automatic logic [7:0] sub_byte(input logic [7:0] v);
        logic [7:0] sq;
        logic [7:0] inv;
        sq  = v;
        inv = 8'h01;
        for (int i = 0; i < 7; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                   ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    // Column mix of one 4-byte column, row 0 in the low byte.
    function automatic logic [31:0] mix_column(input logic [31:0] col);
        logic [7:0] b [4];
        logic [31:0] res;
        for (int r = 0; r < 4; r++) b[r] = col[8*r +: 8];
        for (int r = 0; r < 4; r++) begin
            res[8*r +: 8] = xtime(b[r]) ^ xtime(b[(r+1)%4]) ^ b[(r+1)%4]
                          ^ b[(r+2)%4] ^ b[(r+3)%4];
        end
        return res;
    endfunction

endpackage

// File: rtl/rd256_lane_mix.sv
// Pre-round byte placement for the two lanes. Exchanges the masked bytes
// between the lanes, then permutes each lane with the fixed pattern, so a
// later 4-column row rotation in each lane forms the 8-column rotation.
// Assumes lane 0 holds columns 0-3 and lane 1 holds columns 4-7.
module rd256_lane_mix
    import rd256_pkg::*;
(
    input  logic [LANE_W-1:0] lo_in,
    input  logic [LANE_W-1:0] hi_in,
    output logic [LANE_W-1:0] lo_out,
    output logic [LANE_W-1:0] hi_out
);

    logic [LANE_W-1:0] lo_x;
    logic [LANE_W-1:0] hi_x;

    for (genvar i = 0; i < LANE_BYTES; i++) begin : g_byte
        localparam bit      SWAP = XFER_MASK[8*i+7];
        localparam int      SRC  = int'(PERM_MASK[8*i +: 4]);
        // Lane exchange for byte i.
        assign lo_x[8*i +: 8] = SWAP ? hi_in[8*i +: 8] : lo_in[8*i +: 8];
        assign hi_x[8*i +: 8] = SWAP ? lo_in[8*i +: 8] : hi_in[8*i +: 8];
        // Fixed permutation inside each lane.
        assign lo_out[8*i +: 8] = lo_x[8*SRC +: 8];
        assign hi_out[8*i +: 8] = hi_x[8*SRC +: 8];
    end

endmodule

// File: rtl/rd256_aes_round.sv
// One 128-bit AES encryption round: row rotation, S-box, column mix
// (bypassed when last is high) and key XOR. Purely combinational.
// Assumes column-major byte order with row 0 in the low byte of a column.
module rd256_aes_round
    import rd256_pkg::*;
(
    input  logic [LANE_W-1:0] din,
    input  logic [LANE_W-1:0] key,
    input  logic              last,
    output logic [LANE_W-1:0] dout
);

    for (genvar c = 0; c < COLS_LANE; c++) begin : g_col
        logic [31:0] sb_col;
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int SRC = 4 * ((c + r) % COLS_LANE) + r;
            // Rotated byte through the S-box.
            assign sb_col[8*r +: 8] = sub_byte(din[8*SRC +: 8]);
        end
        // Column mix (unless final round) and key addition.
        assign dout[32*c +: 32] = (last ? sb_col : mix_column(sb_col))
                                ^ key[32*c +: 32];
    end

endmodule

// File: rtl/rd256_round_engine.sv
// Rijndael-256 encryption sequencer. Whitening on start, then one round per
// cycle with the lane placement ahead of two AES round datapaths; the round
// numbered NR omits the column mix. Assumes key_even/key_odd answer
// combinationally for the index on key_round. NR must be at least 1.
module rd256_round_engine
    import rd256_pkg::*;
#(
    parameter int NR = 14,
    parameter int RW = $clog2(NR + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2*LANE_W-1:0] block_in,
    output logic [RW-1:0]       key_round,
    input  logic [LANE_W-1:0]   key_even,
    input  logic [LANE_W-1:0]   key_odd,
    output logic                busy,
    output logic                done,
    output logic [2*LANE_W-1:0] block_out
);

    localparam int NLANE = 2;

    seq_state_t          seq_q;
    logic [RW-1:0]       rnd_q;
    logic [2*LANE_W-1:0] state_q;
    logic                done_q;
    logic                last_rnd;

    logic [LANE_W-1:0] lane_key [NLANE];
    logic [LANE_W-1:0] lane_mix [NLANE];
    logic [LANE_W-1:0] lane_res [NLANE];

    assign lane_key[0] = key_even;
    assign lane_key[1] = key_odd;
    assign last_rnd    = (rnd_q == RW'(NR));

    rd256_lane_mix u_mix (
        .lo_in  (state_q[LANE_W-1:0]),
        .hi_in  (state_q[2*LANE_W-1:LANE_W]),
        .lo_out (lane_mix[0]),
        .hi_out (lane_mix[1])
    );

    for (genvar h = 0; h < NLANE; h++) begin : g_lane
        rd256_aes_round u_round (
            .din  (lane_mix[h]),
            .key  (lane_key[h]),
            .last (last_rnd),
            .dout (lane_res[h])
        );
    end

    // Sequencer: accept a block, step rounds, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SEQ_IDLE;
            rnd_q   <= '0;
            state_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (seq_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= block_in ^ {key_odd, key_even};
                        rnd_q   <= RW'(1);
                        seq_q   <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    state_q <= {lane_res[1], lane_res[0]};
                    if (last_rnd) begin
                        rnd_q  <= '0;
                        seq_q  <= SEQ_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        rnd_q <= rnd_q + RW'(1);
                    end
                end
                default: seq_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output drive.
    assign key_round = (seq_q == SEQ_RUN) ? rnd_q : '0;
    assign busy      = (seq_q == SEQ_RUN);
    assign done      = done_q;
    assign block_out = state_q;

endmodule

// File: rtl/rd256_round_engine_chk.sv
// Port-level protocol checks for rd256_round_engine, attached by bind.
// Assumes NR is at least 1.
module rd256_round_engine_chk #(
    parameter int NR = 14,
    parameter int RW = $clog2(NR + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [RW-1:0]  key_round,
    input logic           busy,
    input logic           done,
    input logic [255:0]   block_out
);

    assert_idle_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> key_round == '0);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && key_round == RW'(1)));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && key_round != RW'(NR)) |=> (busy && key_round == $past(key_round) + RW'(1)));

    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && key_round == RW'(NR)) |=> (done && !busy));

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(block_out));

endmodule

bind rd256_round_engine rd256_round_engine_chk #(.NR(NR), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .key_round (key_round),
    .busy      (busy),
    .done      (done),
    .block_out (block_out)
);

// File: tb/rd256_round_engine_test.sv
// Bench: behavioural 8-column reference updated every cycle and compared at
// each falling edge against all outputs.
module rd256_round_engine_test;

    localparam int NR = 14;
    localparam int RW = $clog2(NR + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [255:0]   block_in = '0;
    logic [RW-1:0]  key_round;
    logic [127:0]   key_even;
    logic [127:0]   key_odd;
    logic           busy;
    logic           done;
    logic [255:0]   block_out;

    logic [255:0]   seed = '0;
    int             n_tests = 0;
    int             n_fail  = 0;
    int             cycles  = 0;

    logic [7:0]     sbox_t [256];
    int             row_off [4] = '{0, 1, 3, 4};

    // reference state
    bit             m_busy = 0;
    bit             m_done = 0;
    int             m_rnd  = 0;
    logic [255:0]   m_state = '0;
    string          m_tag  = "R1";
    string          m_ctag = "R1";

    always #5 clk = ~clk;

    rd256_round_engine #(.NR(NR)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .block_in  (block_in),
        .key_round (key_round),
        .key_even  (key_even),
        .key_odd   (key_odd),
        .busy      (busy),
        .done      (done),
        .block_out (block_out)
    );

    function automatic logic [255:0] key_pair(int idx);
        logic [7:0] t;
        t = 8'(idx * 37 + 5);
        return seed ^ {32{t}};
    endfunction

    always_comb {key_odd, key_even} = key_pair(int'(key_round));

    function automatic logic [7:0] mul2(logic [7:0] x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    endfunction

    // S-box from exp/log tables of generator 3, then the affine map by bits.
    task automatic build_sbox();
        int lg [256];
        logic [7:0] ex [256];
        logic [7:0] p;
        p = 8'h01;
        for (int i = 0; i < 255; i++) begin
            ex[i] = p;
            lg[p] = i;
            p = p ^ mul2(p);
        end
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv;
            logic [7:0] o;
            inv = (v == 0) ? 8'h00 : ex[(255 - lg[v]) % 255];
            for (int b = 0; b < 8; b++)
                o[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8]
                     ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 8'h01) != 0;
            sbox_t[v] = o;
        end
    endtask

    // Wide round from the 8-column definition.
    function automatic logic [255:0] ref_round(logic [255:0] s, logic [255:0] k, bit fin);
        logic [7:0] a [4][8];
        logic [7:0] b [4][8];
        logic [255:0] o;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++) a[r][c] = s[8*(4*c+r) +: 8];
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++) b[r][c] = sbox_t[a[r][(c + row_off[r]) % 8]];
        if (!fin) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] x0, x1, x2, x3;
                x0 = b[0][c]; x1 = b[1][c]; x2 = b[2][c]; x3 = b[3][c];
                b[0][c] = mul2(x0) ^ mul2(x1) ^ x1 ^ x2 ^ x3;
                b[1][c] = x0 ^ mul2(x1) ^ mul2(x2) ^ x2 ^ x3;
                b[2][c] = x0 ^ x1 ^ mul2(x2) ^ mul2(x3) ^ x3;
                b[3][c] = mul2(x0) ^ x0 ^ x1 ^ x2 ^ mul2(x3);
            end
        end
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++) o[8*(4*c+r) +: 8] = b[r][c];
        return o ^ k;
    endfunction

    // Next-cycle reference state from the inputs about to be sampled.
    task automatic model_step(bit r, bit s, logic [255:0] d);
        if (!r) begin
            m_busy = 0; m_done = 0; m_rnd = 0; m_state = '0;
            m_tag = "R1"; m_ctag = "R1";
        end else if (!m_busy) begin
            m_done = 0; m_ctag = "R6";
            if (s) begin
                m_state = d ^ key_pair(0);
                m_busy = 1; m_rnd = 1; m_tag = "R2 R3";
            end else begin
                m_tag = "R8";
            end
        end else begin
            bit fin;
            fin = (m_rnd == NR);
            m_state = ref_round(m_state, key_pair(m_rnd), fin);
            m_tag = fin ? "R5" : (s ? "R7 R4" : "R3 R4");
            m_ctag = s ? "R7 R6" : "R6";
            if (fin) begin
                m_busy = 0; m_done = 1; m_rnd = 0;
            end else begin
                m_done = 0; m_rnd++;
            end
        end
    endtask

    task automatic compare();
        logic [RW+1:0] got_c, exp_c;
        got_c = {busy, done, key_round};
        exp_c = {m_busy, m_done, RW'(m_busy ? m_rnd : 0)};
        n_tests++;
        if (got_c !== exp_c) begin
            n_fail++;
            $display("FAIL %s control {busy,done,key_round} actual %h expected %h",
                     m_ctag, got_c, exp_c);
        end
        n_tests++;
        if (block_out !== m_state) begin
            n_fail++;
            $display("FAIL %s block_out actual %h expected %h", m_tag, block_out, m_state);
        end
    endtask

    task automatic tick(bit r, bit s, logic [255:0] d);
        @(negedge clk);
        compare();
        rst_n = r; start = s; block_in = d;
        model_step(r, s, d);
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    // One block: start, then idle ticks; stray starts while busy if asked.
    task automatic run_block(logic [255:0] d, logic [255:0] sd, bit stray, int tail);
        seed = sd;
        tick(1, 1, d);
        for (int i = 0; i < NR; i++) tick(1, stray && (i % 3 == 1), rnd256());
        for (int i = 0; i < tail; i++) tick(1, 0, rnd256());
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL R6 watchdog actual %0d cycles expected under 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] inc;
        build_sbox();
        for (int i = 0; i < 32; i++) inc[8*i +: 8] = 8'(i);
        // R1: reset
        for (int i = 0; i < 3; i++) tick(0, 0, '0);
        tick(1, 0, '0);
        tick(1, 0, '0);
        // R2 R3 R4 R5: distinct patterns
        run_block('0, '0, 0, 3);
        run_block('1, '1, 0, 3);
        run_block(inc, ~inc, 0, 3);
        run_block(inc ^ {32{8'h5a}}, rnd256(), 0, 4);
        // R7: start pulses while busy
        run_block(rnd256(), rnd256(), 1, 3);
        // R6: back-to-back with start held high
        seed = rnd256();
        for (int i = 0; i < 3 * (NR + 1) + 1; i++) tick(1, 1, rnd256());
        for (int i = 0; i < NR + 3; i++) tick(1, 0, rnd256());
        // R1: reset in mid-block
        seed = rnd256();
        tick(1, 1, rnd256());
        for (int i = 0; i < 5; i++) tick(1, 0, rnd256());
        tick(0, 0, rnd256());
        tick(1, 0, rnd256());
        // further random blocks
        for (int n = 0; n < 6; n++) run_block(rnd256(), rnd256(), n % 2 == 1, 2);
        // R8: long idle hold
        for (int i = 0; i < 6; i++) tick(1, 0, rnd256());
        @(negedge clk);
        compare();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule